// File: doc/BRIEF.md
# Teletext Data Request Generator

This block asks an external teletext data source for one line's worth of bits and tells the downstream inserter on which clocks those bits are valid. It watches the raster pixel counter. On an enabled line it raises a request output at a programmable horizontal position and holds it for a programmable number of clocks. A data-valid strobe of the same length follows a programmable latency later, so that the bits coming back from the source are taken on the correct clocks.

All settings are captured when the pixel counter passes zero, which is the start of a line. A write to a setting in the middle of a line therefore only affects the next line. A start position of zero selects the recommended position for the chosen TV standard. A latency below two clocks is raised to two. Which lines carry teletext is chosen by a per-line mask together with a global enable.

Top module: `ttx_req_gen`

## Requirements
- R1: While reset is low, and after it is released until the first enabled line, `ttx_req` and `bit_valid` are both 0.
- R2: `ins_en` and `line_mask[line_idx]` are sampled on the clock where `pix_cnt` is 0. If either is 0, that line produces no request and no valid strobe.
- R3: On an enabled line, `ttx_req` is 1 starting in the cycle after the clock that sampled `pix_cnt` equal to the captured start position. It stays 1 for exactly the captured `req_len` cycles and rises only once per line. A `req_len` of 0 gives no request and no strobe.
- R4: A `req_start` of 0 selects the standard default start position: 66 (0x42) when `std_ntsc` is 0, and 84 (0x54) when `std_ntsc` is 1. Any other value is used as given.
- R5: `bit_valid` rises exactly D cycles after `ttx_req` rises, where D is the captured latency. It stays high for the same `req_len` cycles.
- R6: A `req_delay` of 0 or 1 is treated as a latency of 2. Values of 2 and above are used as given.
- R7: `req_start`, `req_delay`, `req_len`, `ins_en` and the mask are captured only at line start. A change made later in the line takes effect from the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_en | input | 1 | Global teletext insertion enable |
| std_ntsc | input | 1 | Standard select for the default start: 0 = 625-line, 1 = 525-line |
| req_start | input | PIX_W | Request start pixel; 0 selects the standard default |
| req_delay | input | DLY_W | Clocks from request rise to the first valid bit (minimum 2) |
| req_len | input | LEN_W | Request and strobe length in clocks per line |
| line_mask | input | MASK_N | Per-line insertion enable mask |
| line_idx | input | IDX_W | Index of the current line into the mask |
| pix_cnt | input | PIX_W | Raster pixel counter; 0 marks line start |
| ttx_req | output | 1 | Request output to the teletext source |
| bit_valid | output | 1 | Strobe marking clocks that carry valid returned bits |

## Verification
Full lines are driven with an explicitly set start, and both the request and the strobe are compared clock by clock. This separates an off-by-one in the start comparison from an error in the run length.

Lines with a start of zero under each standard show whether the default table and the standard select are wired correctly. Latencies of 0, 1, 2 and the largest value separate a missing clamp from a wrong delay count.

Lines with the enable off, the mask bit clear, or a zero length show that gating happens at line start. A line whose settings are changed after line start, followed by a line that uses the new values, shows that settings are captured rather than read live.

// File: rtl/ttx_pkg.sv
// Package: shared constants and types for the teletext request generator.
// Assumes nothing beyond being compiled before the modules that import it.
package ttx_pkg;

    // TV standard used to choose the default request position
    typedef enum logic {
        TV_625 = 1'b0,
        TV_525 = 1'b1
    } tv_std_e;

    // Recommended request start positions in pixel clocks
    localparam int PAL_REQ_POS  = 66;
    localparam int NTSC_REQ_POS = 84;

    // Smallest legal request-to-data latency in clocks
    localparam int MIN_REQ_LAT  = 2;

endpackage

// File: rtl/ttx_line_cfg.sv
// Module: ttx_line_cfg
// Captures the per-line settings at line start. It resolves a zero start
// to the standard default and clamps the latency to its minimum. It also
// keeps the "armed" flag that allows exactly one request per line.
// Assumes MASK_N is a power of two so that every line_idx value is in range.
module ttx_line_cfg
    import ttx_pkg::*;
#(
    parameter int PIX_W  = 11,
    parameter int DLY_W  = 4,
    parameter int LEN_W  = 9,
    parameter int MASK_N = 32,
    parameter int IDX_W  = $clog2(MASK_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             fired,
    input  logic             ins_en,
    input  tv_std_e          std_sel,
    input  logic [PIX_W-1:0] req_start,
    input  logic [DLY_W-1:0] req_delay,
    input  logic [LEN_W-1:0] req_len,
    input  logic [MASK_N-1:0] line_mask,
    input  logic [IDX_W-1:0] line_idx,
    output logic [PIX_W-1:0] start_q,
    output logic [DLY_W-1:0] dly_q,
    output logic [LEN_W-1:0] len_q,
    output logic             armed_q
);

    localparam logic [PIX_W-1:0] POS_625 = PIX_W'(PAL_REQ_POS);
    localparam logic [PIX_W-1:0] POS_525 = PIX_W'(NTSC_REQ_POS);
    localparam logic [DLY_W-1:0] LAT_MIN = DLY_W'(MIN_REQ_LAT);

    logic [PIX_W-1:0] start_eff;
    logic [DLY_W-1:0] dly_eff;
    logic             line_ok;

    // Resolve the default start, clamp the latency, and look up line gating
    always_comb begin
        if (req_start == '0) begin
            start_eff = (std_sel == TV_525) ? POS_525 : POS_625;
        end else begin
            start_eff = req_start;
        end
        dly_eff = (req_delay < LAT_MIN) ? LAT_MIN : req_delay;
        line_ok = ins_en && line_mask[line_idx];
    end

    // Latch settings at line start; disarm once the request has fired
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= POS_625;
            dly_q   <= LAT_MIN;
            len_q   <= '0;
            armed_q <= 1'b0;
        end else if (line_start) begin
            start_q <= start_eff;
            dly_q   <= dly_eff;
            len_q   <= req_len;
            armed_q <= line_ok;
        end else if (fired) begin
            armed_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ttx_pulse_run.sv
// Module: ttx_pulse_run
// Produces a registered run of run_len high cycles, starting in the cycle
// after a go pulse. A go with run_len of 0 is ignored.
// Assumes go does not arrive again while a run is still in progress.
module ttx_pulse_run #(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [LEN_W-1:0] run_len,
    output logic             active
);

    logic [LEN_W-1:0] remain;

    // Load the run on go, then count the remaining cycles down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            remain <= '0;
        end else if (go && (run_len != '0)) begin
            active <= 1'b1;
            remain <= run_len - LEN_W'(1);
        end else if (active) begin
            if (remain == '0) begin
                active <= 1'b0;
            end else begin
                remain <= remain - LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/ttx_lat_timer.sv
// Module: ttx_lat_timer
// After a start pulse, emits a single-cycle pulse timed so that a following
// ttx_pulse_run starts exactly lat clocks after the run that the same start
// pulse launched.
// Assumes lat >= 2. The caller clamps it.
module ttx_lat_timer #(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DLY_W-1:0] lat,
    output logic             due
);

    logic             pending;
    logic [DLY_W-1:0] wait_cnt;

    // Count the latency down and raise due one clock before the strobe starts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            wait_cnt <= '0;
            due      <= 1'b0;
        end else begin
            due <= 1'b0;
            if (start) begin
                pending  <= 1'b1;
                wait_cnt <= lat;
            end else if (pending) begin
                if (wait_cnt == DLY_W'(2)) begin
                    due     <= 1'b1;
                    pending <= 1'b0;
                end else begin
                    wait_cnt <= wait_cnt - DLY_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/ttx_req_gen.sv
// Module: ttx_req_gen (top)
// Teletext data request generator. It captures the settings at pixel 0 and
// fires a request when the pixel counter reaches the captured start. A data
// valid strobe of the same length follows the captured latency later.
// Assumes pix_cnt advances by one each clock, is 0 for exactly one clock per
// line, and that start + latency + length fits inside the line.
module ttx_req_gen
    import ttx_pkg::*;
#(
    parameter int PIX_W  = 11,
    parameter int DLY_W  = 4,
    parameter int LEN_W  = 9,
    parameter int MASK_N = 32,
    parameter int IDX_W  = $clog2(MASK_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_en,
    input  logic              std_ntsc,
    input  logic [PIX_W-1:0]  req_start,
    input  logic [DLY_W-1:0]  req_delay,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [MASK_N-1:0] line_mask,
    input  logic [IDX_W-1:0]  line_idx,
    input  logic [PIX_W-1:0]  pix_cnt,
    output logic              ttx_req,
    output logic              bit_valid
);

    logic             line_start;
    logic             fire;
    logic             valid_due;
    logic [PIX_W-1:0] start_q;
    logic [DLY_W-1:0] dly_q;
    logic [LEN_W-1:0] len_q;
    logic             armed_q;
    tv_std_e          std_sel;

    // Decode line start, the standard select and the request fire condition
    always_comb begin
        line_start = (pix_cnt == '0);
        std_sel    = tv_std_e'(std_ntsc);
        fire       = armed_q && !line_start && (pix_cnt == start_q) && (len_q != '0);
    end

    ttx_line_cfg #(
        .PIX_W (PIX_W),
        .DLY_W (DLY_W),
        .LEN_W (LEN_W),
        .MASK_N(MASK_N),
        .IDX_W (IDX_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .fired     (fire),
        .ins_en    (ins_en),
        .std_sel   (std_sel),
        .req_start (req_start),
        .req_delay (req_delay),
        .req_len   (req_len),
        .line_mask (line_mask),
        .line_idx  (line_idx),
        .start_q   (start_q),
        .dly_q     (dly_q),
        .len_q     (len_q),
        .armed_q   (armed_q)
    );

    ttx_pulse_run #(.LEN_W(LEN_W)) u_req_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (fire),
        .run_len(len_q),
        .active (ttx_req)
    );

    ttx_lat_timer #(.DLY_W(DLY_W)) u_lat (
        .clk  (clk),
        .rst_n(rst_n),
        .start(fire),
        .lat  (dly_q),
        .due  (valid_due)
    );

    ttx_pulse_run #(.LEN_W(LEN_W)) u_valid_run (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (valid_due),
        .run_len(len_q),
        .active (bit_valid)
    );

endmodule

// File: rtl/ttx_req_gen_chk.sv
// Module: ttx_req_gen_chk
// Property checker bound to ttx_req_gen. It keeps its own line-start copies
// of the gating, length and latency, and checks the outputs against them.
module ttx_req_gen_chk #(
    parameter int PIX_W  = 11,
    parameter int DLY_W  = 4,
    parameter int LEN_W  = 9,
    parameter int MASK_N = 32,
    parameter int IDX_W  = $clog2(MASK_N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ins_en,
    input logic [DLY_W-1:0]  req_delay,
    input logic [LEN_W-1:0]  req_len,
    input logic [MASK_N-1:0] line_mask,
    input logic [IDX_W-1:0]  line_idx,
    input logic [PIX_W-1:0]  pix_cnt,
    input logic              ttx_req,
    input logic              bit_valid
);

    logic             ok_c;
    logic [LEN_W-1:0] len_c;
    logic [7:0]       lat_c;
    logic [LEN_W:0]   run_c;
    logic [7:0]       since_c;
    logic             seen_c;

    // Shadow copies of the settings at line start, plus run and latency counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_c    <= 1'b0;
            len_c   <= '0;
            lat_c   <= 8'd2;
            run_c   <= '0;
            since_c <= '0;
            seen_c  <= 1'b0;
        end else begin
            if (pix_cnt == '0) begin
                ok_c   <= ins_en && line_mask[line_idx];
                len_c  <= req_len;
                lat_c  <= (req_delay < DLY_W'(2)) ? 8'd2 : 8'(req_delay);
                seen_c <= 1'b0;
            end else if (ttx_req) begin
                seen_c <= 1'b1;
            end
            run_c <= ttx_req ? run_c + 1'b1 : '0;
            if (ttx_req && !seen_c && (pix_cnt != '0)) begin
                since_c <= 8'd1;
            end else if (since_c != 8'hFF) begin
                since_c <= since_c + 8'd1;
            end
        end
    end

    // R1: nothing is driven while reset is low
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (!ttx_req && !bit_valid));

    // R2: a line gated off at its start carries no request
    a_r2_gated_line: assert property (@(posedge clk) disable iff (!rst_n)
        !ok_c |-> !ttx_req);

    // R3: each request run lasts exactly the captured length
    a_r3_req_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ttx_req) |-> (run_c == (LEN_W+1)'(len_c)));

    // R3: only one request rise per line
    a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ttx_req) && (pix_cnt != '0)) |-> !seen_c);

    // R5, R6: the strobe rises the clamped latency after the request rose
    a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bit_valid) |-> (since_c == lat_c));

endmodule

bind ttx_req_gen ttx_req_gen_chk #(
    .PIX_W (PIX_W),
    .DLY_W (DLY_W),
    .LEN_W (LEN_W),
    .MASK_N(MASK_N),
    .IDX_W (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_en   (ins_en),
    .req_delay(req_delay),
    .req_len  (req_len),
    .line_mask(line_mask),
    .line_idx (line_idx),
    .pix_cnt  (pix_cnt),
    .ttx_req  (ttx_req),
    .bit_valid(bit_valid)
);

// File: tb/ttx_req_gen_bench.sv
// Directed bench for ttx_req_gen: one task per scenario, each line checked
// clock by clock against expectations derived from the requirements.
module ttx_req_gen_bench;

    localparam int PIX_W    = 11;
    localparam int DLY_W    = 4;
    localparam int LEN_W    = 9;
    localparam int MASK_N   = 32;
    localparam int IDX_W    = 5;
    localparam int LINE_LEN = 240;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ins_en = 1'b0;
    logic              std_ntsc = 1'b0;
    logic [PIX_W-1:0]  req_start = '0;
    logic [DLY_W-1:0]  req_delay = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic [MASK_N-1:0] line_mask = '1;
    logic [IDX_W-1:0]  line_idx = '0;
    logic [PIX_W-1:0]  pix_cnt = 11'd1;
    logic              ttx_req;
    logic              bit_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ttx_req_gen #(
        .PIX_W(PIX_W), .DLY_W(DLY_W), .LEN_W(LEN_W),
        .MASK_N(MASK_N), .IDX_W(IDX_W)
    ) u_ttx_req_gen (
        .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .std_ntsc(std_ntsc),
        .req_start(req_start), .req_delay(req_delay), .req_len(req_len),
        .line_mask(line_mask), .line_idx(line_idx), .pix_cnt(pix_cnt),
        .ttx_req(ttx_req), .bit_valid(bit_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one full line. Settings are applied before pixel 0; the mid_* values
    // overwrite them at pixel 10. Mismatch counts are compared with zero.
    task automatic run_line(input string req, input bit en, input bit mask_on,
                            input bit ntsc, input int start, input int dly,
                            input int len, input int mid_start, input int mid_dly,
                            input int mid_len, input bit exp_on, input int exp_s,
                            input int exp_d, input int exp_l);
        int req_err = 0;
        int val_err = 0;
        int req_hi  = 0;
        @(negedge clk);
        ins_en    = en;
        std_ntsc  = ntsc;
        req_start = PIX_W'(start);
        req_delay = DLY_W'(dly);
        req_len   = LEN_W'(len);
        line_idx  = line_idx + 1'b1;
        line_mask = '1;
        if (!mask_on) line_mask[line_idx] = 1'b0;
        for (int p = 0; p < LINE_LEN; p++) begin
            if (p != 0) @(negedge clk);
            pix_cnt = PIX_W'(p);
            if (p == 10) begin
                req_start = PIX_W'(mid_start);
                req_delay = DLY_W'(mid_dly);
                req_len   = LEN_W'(mid_len);
                ins_en    = 1'b1;
                line_mask = '1;
            end
            @(posedge clk);
            #1;
            if (ttx_req !== (exp_on && p >= exp_s && p < exp_s + exp_l)) req_err++;
            if (bit_valid !== (exp_on && p >= exp_s + exp_d && p < exp_s + exp_d + exp_l)) val_err++;
            if (ttx_req === 1'b1) req_hi++;
        end
        check({req, " request waveform mismatches"}, req_err, 0);
        check({req, " strobe waveform mismatches"}, val_err, 0);
        check({req, " request high cycles"}, req_hi, exp_on ? exp_l : 0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 outputs low in reset", {31'd0, ttx_req} + {31'd0, bit_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: a disabled line after reset stays quiet
        run_line("R1", 1'b0, 1'b1, 1'b0, 20, 5, 30, 20, 5, 30, 1'b0, 0, 0, 0);
    endtask

    task automatic t_basic();
        run_line("R3 R5 explicit start", 1'b1, 1'b1, 1'b0, 20, 5, 30, 20, 5, 30, 1'b1, 20, 5, 30);
        run_line("R3 R5 other start", 1'b1, 1'b1, 1'b1, 37, 7, 12, 37, 7, 12, 1'b1, 37, 7, 12);
    endtask

    task automatic t_gating();
        run_line("R2 enable off", 1'b0, 1'b1, 1'b0, 20, 5, 30, 20, 5, 30, 1'b0, 0, 0, 0);
        run_line("R2 mask bit clear", 1'b1, 1'b0, 1'b0, 20, 5, 30, 20, 5, 30, 1'b0, 0, 0, 0);
        run_line("R3 zero length", 1'b1, 1'b1, 1'b0, 20, 5, 0, 20, 5, 0, 1'b0, 0, 0, 0);
    endtask

    task automatic t_defaults();
        run_line("R4 625 default", 1'b1, 1'b1, 1'b0, 0, 3, 16, 0, 3, 16, 1'b1, 66, 3, 16);
        run_line("R4 525 default", 1'b1, 1'b1, 1'b1, 0, 3, 16, 0, 3, 16, 1'b1, 84, 3, 16);
    endtask

    task automatic t_clamp();
        run_line("R6 delay 0", 1'b1, 1'b1, 1'b0, 25, 0, 8, 25, 0, 8, 1'b1, 25, 2, 8);
        run_line("R6 delay 1", 1'b1, 1'b1, 1'b0, 25, 1, 8, 25, 1, 8, 1'b1, 25, 2, 8);
        run_line("R6 delay 2", 1'b1, 1'b1, 1'b0, 25, 2, 8, 25, 2, 8, 1'b1, 25, 2, 8);
        run_line("R5 delay 15 len 1", 1'b1, 1'b1, 1'b0, 30, 15, 1, 30, 15, 1, 1'b1, 30, 15, 1);
    endtask

    task automatic t_midline();
        // R7: settings changed at pixel 10 leave this line untouched
        run_line("R7 mid-line write", 1'b1, 1'b1, 1'b0, 20, 4, 25, 50, 9, 5, 1'b1, 20, 4, 25);
        // R7: the new values apply on the following line
        run_line("R7 next line", 1'b1, 1'b1, 1'b0, 50, 9, 5, 50, 9, 5, 1'b1, 50, 9, 5);
        // R7: a disabled line is not revived by enabling mid-line
        run_line("R7 late enable", 1'b0, 1'b0, 1'b0, 20, 4, 25, 20, 4, 25, 1'b0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_gating();
        t_defaults();
        t_clamp();
        t_midline();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule